// File: doc/BRIEF.md
# Pipelined Physical-Register Free List

This block keeps the pool of unused physical register numbers for a renaming front end. It is a circular list with a read position (head) and a write position (tail). In each cycle up to `RW` rename lanes can take a register from it, and up to `CW` commit lanes can hand retired registers back to it. The head is kept as a one-hot vector next to its binary form, so each lane picks its entry with an AND-OR select and needs no index decoder.

Returned registers go through one pipeline register before they are written. The cycle after they are reported, they are written into the list and the tail grows by a count that was formed one cycle earlier. The popcount of the returning lanes and the addition to the tail therefore sit in different cycles. The grant flag is a register, set from the number of entries the list will hold at the start of the next cycle. A rollback input moves the head back to a value the user saved earlier. This returns every register handed out after that point in one cycle.

After reset the list holds every physical number except zero, in rising order. Zero is the one to which all architectural registers are mapped at start-up.

Top module: `regfree_list`

## Requirements
- R1: After reset `can_alloc` is 1 and `head_ptr` is 0. The list holds 1, 2, ..., PREGS-1 in that order, so the first granted register is 1, and register 0 is never handed out unless a user returns it.
- R2: When `can_alloc` is 1 and `rollback_vld` is 0, a requesting lane k gets the entry at position head + (the number of requesting lanes below k). The head then advances by the number of requesting lanes. Lanes granted in the same cycle get different registers.
- R3: When `can_alloc` is 0, requests are ignored and `head_ptr` does not move.
- R4: `can_alloc` is 1 in a cycle exactly when the number of written entries between head and tail at the start of that cycle is greater than RW. Returns that are still in the pipeline register are not counted.
- R5: A register reported on the free port in cycle t is written in the edge that ends cycle t+1. It first counts toward `can_alloc` in cycle t+2. Returned registers are handed out again in the order they came back, with the lower lane first inside one cycle.
- R6: When `rollback_vld` is 1, `head_ptr` takes the value of `rollback_ptr` at the next edge, and requests in that cycle are ignored.
- R7: A return reported in the same cycle as a rollback is still written and counted.
- R8: `head_ptr` is log2(PREGS)+1 bits wide. The top bit toggles each time the head passes the last entry, so a full list and an empty list can be told apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | RW | Per-lane request for a register |
| alloc_idx | output | RW*log2(PREGS) | Register granted to each lane (valid when that lane requests and `can_alloc` is 1) |
| can_alloc | output | 1 | Registered grant flag for this cycle |
| free_vld | input | CW | Per-lane return valid |
| free_idx | input | CW*log2(PREGS) | Register number returned on each lane |
| rollback_vld | input | 1 | Move the head back to `rollback_ptr` |
| rollback_ptr | input | log2(PREGS)+1 | Saved head value, wrap bit included |
| head_ptr | output | log2(PREGS)+1 | Current head, for the user to save before speculation |

## Verification
Two pairs of functions can fall in the same cycle. Returns can arrive while lanes are being granted, and a rollback can land together with returns. The bench runs long stretches in which lanes request and commit lanes return previously granted registers in the same cycles. A reference list, kept in the bench and updated with the two-cycle delay on returns, predicts every granted number, the head and the grant flag, and each prediction is compared in its own cycle. A rollback is also issued in a cycle that carries two returns. The bench then checks that the head snaps back, that the same registers are granted again, and that the returned pair is allocatable two cycles later.

// File: rtl/regfree_pkg.sv
package regfree_pkg;
    // Default sizing shared by the list and its users
    localparam int REGFREE_PREGS_DEF = 16;
    localparam int REGFREE_RW_DEF    = 2;
    localparam int REGFREE_CW_DEF    = 2;
endpackage

// File: rtl/regfree_prefix_count.sv
// Exclusive prefix count of set bits, plus the total
module regfree_prefix_count #(
    parameter int N  = 2,
    parameter int OW = $clog2(N + 1)
) (
    input  logic [N-1:0]         vec,
    output logic [N-1:0][OW-1:0] pre,
    output logic [OW-1:0]        total
);
    logic [OW-1:0] acc;
    always_comb begin
        acc = '0;
        for (int i = 0; i < N; i++) begin
            pre[i] = acc;
            acc    = acc + OW'(vec[i]);
        end
        total = acc;
    end
endmodule

// File: rtl/regfree_oh_rotate.sv
// Rotate a one-hot position forward by a small amount
module regfree_oh_rotate #(
    parameter int N  = 16,
    parameter int AW = 2
) (
    input  logic [N-1:0]  in_oh,
    input  logic [AW-1:0] amt,
    output logic [N-1:0]  out_oh
);
    always_comb begin
        out_oh = '0;
        for (int i = 0; i < N; i++) begin
            out_oh[(i + int'(amt)) % N] = in_oh[i];
        end
    end
endmodule

// File: rtl/regfree_oh_mux.sv
// AND-OR select of one entry by a one-hot vector
module regfree_oh_mux #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] data,
    output logic [W-1:0]        out
);
    always_comb begin
        out = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) out = out | data[i];
        end
    end
endmodule

// File: rtl/regfree_list.sv
module regfree_list
    import regfree_pkg::*;
#(
    parameter int PREGS = REGFREE_PREGS_DEF,
    parameter int RW    = REGFREE_RW_DEF,
    parameter int CW    = REGFREE_CW_DEF
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [RW-1:0]                     alloc_req,
    output logic [RW-1:0][$clog2(PREGS)-1:0]  alloc_idx,
    output logic                              can_alloc,
    input  logic [CW-1:0]                     free_vld,
    input  logic [CW-1:0][$clog2(PREGS)-1:0]  free_idx,
    input  logic                              rollback_vld,
    input  logic [$clog2(PREGS):0]            rollback_ptr,
    output logic [$clog2(PREGS):0]            head_ptr
);
    localparam int IW   = $clog2(PREGS);
    localparam int PW   = IW + 1;
    localparam int RCW  = $clog2(RW + 1);
    localparam int CNTW = $clog2(CW + 1);

    typedef struct packed {
        logic [PW-1:0]              head;
        logic [PREGS-1:0]           head_oh;
        logic [PW-1:0]              tail;
        logic                       can;
        logic [CW-1:0]              pvld;
        logic [CW-1:0][IW-1:0]      pidx;
        logic [CNTW-1:0]            pcnt;
        logic [PREGS-1:0][IW-1:0]   slots;
    } st_t;

    function automatic st_t rst_state();
        st_t s;
        s         = '0;
        s.head_oh = PREGS'(1);
        s.tail    = PW'(PREGS - 1);
        s.can     = (PREGS - 1) > RW;
        for (int i = 0; i < PREGS - 1; i++) s.slots[i] = IW'(i + 1);
        return s;
    endfunction

    localparam st_t ST_RST = rst_state();

    st_t st_q, st_d;

    logic [RW-1:0][RCW-1:0] apre;
    logic [RCW-1:0]         atotal;
    logic [PREGS-1:0]       head_oh_adv;
    logic [IW-1:0]          woff;
    logic [PW-1:0]          cnt_d;
    logic                   do_alloc;

    regfree_prefix_count #(.N(RW), .OW(RCW)) u_apre (
        .vec   (alloc_req),
        .pre   (apre),
        .total (atotal)
    );

    // Per-lane one-hot select: head rotated by the lane's compacted offset
    for (genvar k = 0; k < RW; k++) begin : g_lane
        logic [PREGS-1:0] sel_oh;
        regfree_oh_rotate #(.N(PREGS), .AW(RCW)) u_rot (
            .in_oh  (st_q.head_oh),
            .amt    (apre[k]),
            .out_oh (sel_oh)
        );
        regfree_oh_mux #(.N(PREGS), .W(IW)) u_mux (
            .sel  (sel_oh),
            .data (st_q.slots),
            .out  (alloc_idx[k])
        );
    end

    regfree_oh_rotate #(.N(PREGS), .AW(RCW)) u_head_rot (
        .in_oh  (st_q.head_oh),
        .amt    (atotal),
        .out_oh (head_oh_adv)
    );

    always_comb begin
        st_d     = st_q;
        do_alloc = st_q.can && !rollback_vld;
        woff     = '0;

        // Head update: rollback wins over allocation
        if (rollback_vld) begin
            st_d.head    = rollback_ptr;
            st_d.head_oh = '0;
            st_d.head_oh[rollback_ptr[IW-1:0]] = 1'b1;
        end else if (do_alloc) begin
            st_d.head    = st_q.head + PW'(atotal);
            st_d.head_oh = head_oh_adv;
        end

        // Stage 2: write last cycle's returns, add last cycle's popcount
        for (int j = 0; j < CW; j++) begin
            if (st_q.pvld[j]) begin
                st_d.slots[st_q.tail[IW-1:0] + woff] = st_q.pidx[j];
                woff = woff + IW'(1);
            end
        end
        st_d.tail = st_q.tail + PW'(st_q.pcnt);

        // Stage 1: capture returns and count them
        st_d.pvld = free_vld;
        st_d.pidx = free_idx;
        st_d.pcnt = CNTW'($countones(free_vld));

        // Grant flag for the next cycle, pending returns not counted
        cnt_d    = st_d.tail - st_d.head;
        st_d.can = int'(cnt_d) > RW;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign can_alloc = st_q.can;
    assign head_ptr  = st_q.head;
endmodule

// File: rtl/regfree_list_chk.sv
module regfree_list_chk #(
    parameter int PREGS = 16,
    parameter int RW    = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [RW-1:0]                     alloc_req,
    input logic [RW-1:0][$clog2(PREGS)-1:0]  alloc_idx,
    input logic                              can_alloc,
    input logic                              rollback_vld,
    input logic [$clog2(PREGS):0]            rollback_ptr,
    input logic [$clog2(PREGS):0]            head_ptr
);
    localparam int PW = $clog2(PREGS) + 1;

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!can_alloc && !rollback_vld) |=> $stable(head_ptr));

    // R6
    rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_vld |=> head_ptr == $past(rollback_ptr));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (can_alloc && !rollback_vld) |=>
            head_ptr == $past(head_ptr) + PW'($countones($past(alloc_req))));

    if (RW > 1) begin : g_pair
        // R2
        distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (can_alloc && !rollback_vld && alloc_req[0] && alloc_req[1])
                |-> alloc_idx[0] != alloc_idx[1]);
    end

    for (genvar k = 0; k < RW; k++) begin : g_zero
        // R1
        zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (can_alloc && alloc_req[k]) |-> alloc_idx[k] != '0);
    end
endmodule

bind regfree_list regfree_list_chk #(.PREGS(PREGS), .RW(RW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_req    (alloc_req),
    .alloc_idx    (alloc_idx),
    .can_alloc    (can_alloc),
    .rollback_vld (rollback_vld),
    .rollback_ptr (rollback_ptr),
    .head_ptr     (head_ptr)
);

// File: tb/regfree_list_test.sv
module regfree_list_test;
    localparam int PREGS = 16;
    localparam int RW    = 2;
    localparam int CW    = 2;
    localparam int IW    = 4;
    localparam int PW    = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                    rst_n;
    logic [RW-1:0]           alloc_req;
    logic [RW-1:0][IW-1:0]   alloc_idx;
    logic                    can_alloc;
    logic [CW-1:0]           free_vld;
    logic [CW-1:0][IW-1:0]   free_idx;
    logic                    rollback_vld;
    logic [PW-1:0]           rollback_ptr;
    logic [PW-1:0]           head_ptr;

    regfree_list #(.PREGS(PREGS), .RW(RW), .CW(CW)) uut (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int mlist[PREGS];
    int mhead, mtail;
    int pend_q[$], outst[$], exp_q[$], lane_q[$], tag_q[$];
    event mon_ev;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: pops expected grants when the driver signals a sample point
    initial forever begin
        @(mon_ev);
        while (exp_q.size() > 0) begin
            int v, k, t;
            v = exp_q.pop_front();
            k = lane_q.pop_front();
            t = tag_q.pop_front();
            chk(int'(alloc_idx[k]) == v, t ? "R5 grant order" : "R2 grant", int'(alloc_idx[k]), v);
        end
    end

    // One cycle of stimulus, prediction and model update
    task automatic step(input logic [RW-1:0] req, input logic [CW-1:0] fv,
                        input int f0, input int f1, input bit rb, input int rbp);
        bit exp_can;
        int n;
        @(negedge clk);
        alloc_req    = req;
        free_vld     = fv;
        free_idx[0]  = IW'(f0);
        free_idx[1]  = IW'(f1);
        rollback_vld = rb;
        rollback_ptr = PW'(rbp);
        #5;
        exp_can = ((mtail - mhead + 2 * PREGS) % (2 * PREGS)) > RW;
        chk(can_alloc == exp_can, "R4 can_alloc", int'(can_alloc), int'(exp_can));
        chk(int'(head_ptr) == mhead, "R8 head_ptr", int'(head_ptr), mhead);
        n = 0;
        if (exp_can && !rb) begin
            for (int k = 0; k < RW; k++) begin
                if (req[k]) begin
                    int v;
                    v = mlist[(mhead + n) % PREGS];
                    exp_q.push_back(v);
                    lane_q.push_back(k);
                    tag_q.push_back(0);
                    outst.push_back(v);
                    n++;
                end
            end
        end
        -> mon_ev;
        #1;
        if (rb) mhead = rbp;
        else    mhead = (mhead + n) % (2 * PREGS);
        while (pend_q.size() > 0) begin
            mlist[mtail % PREGS] = pend_q.pop_front();
            mtail = (mtail + 1) % (2 * PREGS);
        end
        if (fv[0]) pend_q.push_back(f0);
        if (fv[1]) pend_q.push_back(f1);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int h, a, b, c, d, save;
        int rolled[4];
        logic [7:0] lfsr;
        rst_n = 1'b0;
        alloc_req = '0; free_vld = '0; free_idx = '0;
        rollback_vld = 1'b0; rollback_ptr = '0;
        for (int i = 0; i < PREGS; i++) mlist[i] = (i < PREGS - 1) ? i + 1 : 0;
        mhead = 0;
        mtail = PREGS - 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(can_alloc == 1'b1, "R1 reset can_alloc", int'(can_alloc), 1);
        chk(head_ptr == '0, "R1 reset head_ptr", int'(head_ptr), 0);
        rst_n = 1'b1;

        step(2'b11, 2'b00, 0, 0, 0, 0);
        chk(alloc_idx[0] == 4'd1, "R1 first grant", int'(alloc_idx[0]), 1);
        chk(alloc_idx[1] == 4'd2, "R1 second grant", int'(alloc_idx[1]), 2);
        step(2'b11, 2'b00, 0, 0, 0, 0);
        // R2 only upper lane requests: it takes the head entry
        step(2'b10, 2'b00, 0, 0, 0, 0);
        chk(alloc_idx[1] == 4'd5, "R2 compacted lane", int'(alloc_idx[1]), 5);
        repeat (4) step(2'b11, 2'b00, 0, 0, 0, 0);

        // Two entries left: grant flag low, request ignored
        step(2'b00, 2'b00, 0, 0, 0, 0);
        chk(can_alloc == 1'b0, "R4 low at two left", int'(can_alloc), 0);
        h = int'(head_ptr);
        step(2'b11, 2'b00, 0, 0, 0, 0);
        step(2'b00, 2'b00, 0, 0, 0, 0);
        chk(int'(head_ptr) == h, "R3 head held", int'(head_ptr), h);

        // Two-cycle delay on returns
        a = outst.pop_front(); b = outst.pop_front();
        step(2'b00, 2'b11, a, b, 0, 0);
        c = outst.pop_front(); d = outst.pop_front();
        step(2'b00, 2'b11, c, d, 0, 0);
        chk(can_alloc == 1'b0, "R5 not yet counted", int'(can_alloc), 0);
        step(2'b11, 2'b00, 0, 0, 0, 0);
        chk(can_alloc == 1'b1, "R5 counted at t+2", int'(can_alloc), 1);
        step(2'b11, 2'b00, 0, 0, 0, 0);
        chk(int'(alloc_idx[0]) == a, "R5 returned lane0 first", int'(alloc_idx[0]), a);
        chk(int'(alloc_idx[1]) == b, "R5 returned lane1 next", int'(alloc_idx[1]), b);

        // Refill before rollback test
        repeat (4) begin
            int x, y;
            x = outst.pop_front(); y = outst.pop_front();
            step(2'b00, 2'b11, x, y, 0, 0);
        end
        step(2'b00, 2'b00, 0, 0, 0, 0);
        step(2'b00, 2'b00, 0, 0, 0, 0);

        // Rollback with returns in the same cycle
        save = int'(head_ptr);
        step(2'b11, 2'b00, 0, 0, 0, 0);
        rolled[0] = int'(alloc_idx[0]); rolled[1] = int'(alloc_idx[1]);
        step(2'b11, 2'b00, 0, 0, 0, 0);
        rolled[2] = int'(alloc_idx[0]); rolled[3] = int'(alloc_idx[1]);
        repeat (4) void'(outst.pop_back());
        a = outst.pop_front(); b = outst.pop_front();
        step(2'b11, 2'b11, a, b, 1, save);
        step(2'b00, 2'b00, 0, 0, 0, 0);
        chk(int'(head_ptr) == save, "R6 head restored", int'(head_ptr), save);
        step(2'b11, 2'b00, 0, 0, 0, 0);
        chk(int'(alloc_idx[0]) == rolled[0], "R6 regrant", int'(alloc_idx[0]), rolled[0]);
        chk(int'(alloc_idx[1]) == rolled[1], "R6 regrant", int'(alloc_idx[1]), rolled[1]);
        h = (mtail - mhead + 2 * PREGS) % (2 * PREGS);
        chk(h >= 2, "R7 returns kept across rollback", h, 2);

        // Mixed traffic: grants and returns in the same cycles, head wraps
        lfsr = 8'h5a;
        repeat (120) begin
            logic [CW-1:0] fv;
            int x, y;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            fv = '0; x = 0; y = 0;
            if (lfsr[2] && outst.size() > 0) begin fv[0] = 1'b1; x = outst.pop_front(); end
            if (lfsr[3] && outst.size() > 0) begin fv[1] = 1'b1; y = outst.pop_front(); end
            step(lfsr[1:0], fv, x, y, 0, 0);
        end
        step(2'b00, 2'b00, 0, 0, 0, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule